// File: doc/BRIEF.md
# Serial Attenuator Programming Master

This block sits on the host side of a board and programs digital step attenuators that listen on a three-wire serial link (data, clock, latch). A request carries an attenuation value in quarter-dB units and a 3-bit target address. The block turns the request into a 16-bit frame and shifts it out least significant bit first. The serial clock is divided down from the system clock. After the last bit the block raises the latch line for a bounded pulse. Every setup, hold, phase and pulse width is a parameter counted in system clock cycles.

The attenuator settles slowly, so it may only be updated at a limited rate. The block therefore keeps a minimum spacing between successive latch pulses and holds its ready output low until that spacing has elapsed. Requests enter through a valid/ready handshake. A one-cycle done pulse marks the end of each update. The link is write-only, so nothing is read back.

Top module: `atten_serial_master`

## Requirements
- R1: The 7-bit attenuation code equals the request value (quarter-dB units) when that value is at most 127, and is 127 for any larger value.
- R2: The frame is 16 bits wide: bits 6..0 hold the code and bits 10..8 hold the address. It is sent bit 0 first, one bit per rising edge of ser_clk, with exactly 16 rising edges per update.
- R3: Frame bit 7 and frame bits 15..11 are always sent as 0.
- R4: During shifting, each high phase and each low phase of ser_clk lasts at least HALF_CYC system cycles. ser_clk idles low.
- R5: ser_data changes only in the cycle where ser_clk falls (or when shifting starts, with ser_clk low). It stays stable for the whole high phase.
- R6: ser_le rises no sooner than HALF_CYC + LE_SU_CYC system cycles after the last rising edge of ser_clk. ser_clk is low whenever ser_le is high.
- R7: ser_le stays high for at least LE_PW_CYC system cycles per update.
- R8: Two successive rising edges of ser_le are at least GAP_CYC system cycles apart.
- R9: req_ready is high only when no update is in progress and the spacing of R8 has elapsed. A request is taken only on a cycle with req_valid and req_ready both high. A request presented while req_ready is low is ignored.
- R10: done is high for exactly one cycle: the first cycle in which ser_le is low again after a latch pulse.
- R11: During and after reset, ser_clk, ser_data, ser_le and done are 0 and req_ready is 1. A reset in the middle of a frame produces no latch pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_qdb | input | QDB_W | Requested attenuation in quarter-dB units |
| req_addr | input | 3 | Target attenuator address |
| ser_clk | output | 1 | Serial shift clock to the attenuator |
| ser_data | output | 1 | Serial data to the attenuator |
| ser_le | output | 1 | Latch pulse that applies the shifted frame |
| done | output | 1 | One-cycle pulse at the end of an update |

## Verification
The hardest situation to reach is a request arriving while the block cannot take it. It arises either during a frame or in the quiet window after a latch pulse, when the rate limit still holds req_ready low. The bench holds req_valid high with a different value across a whole frame and on into the quiet window. It then confirms that only the first frame was latched. It also checks that the spacing between latch pulses, measured at the pins, never falls below the limit when requests are issued back to back. A reset asserted in the middle of a frame covers the case of an aborted frame.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;
  localparam int FRAME_W  = 16;
  localparam int CODE_W   = 7;
  localparam int ADDR_W   = 3;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_SHIFT, SEQ_LATCH} seq_state_e;
  typedef enum logic [1:0] {LP_IDLE, LP_SETUP, LP_HIGH} lp_state_e;

  // Saturate a quarter-dB request to the largest code the attenuator knows.
  function automatic logic [CODE_W-1:0] clamp_code(input logic [15:0] qdb);
    if (qdb > 16'(CODE_MAX)) return CODE_W'(CODE_MAX);
    return qdb[CODE_W-1:0];
  endfunction

  // Low byte: code with its top bit forced to 0. High byte: address, upper bits zero.
  function automatic logic [FRAME_W-1:0] build_frame(input logic [CODE_W-1:0] code,
                                                     input logic [ADDR_W-1:0] addr);
    return {5'b0, addr, 1'b0, code};
  endfunction
endpackage

// File: rtl/atten_frame_build.sv
module atten_frame_build
  import atten_ser_pkg::*;
#(
  parameter int QDB_W = 8
) (
  input  logic [QDB_W-1:0]  qdb_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [15:0]       qdb_ext;
  logic [CODE_W-1:0] code;

  assign qdb_ext = 16'(qdb_i);
  assign code    = clamp_code(qdb_ext);
  assign frame_o = build_frame(code, addr_i);
endmodule

// File: rtl/atten_bit_shifter.sv
module atten_bit_shifter
  import atten_ser_pkg::*;
#(
  parameter int HALF_CYC = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sclk_o,
  output logic               sdata_o,
  output logic               done_o
);
  localparam int PH_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BIT_W = $clog2(FRAME_W);

  logic               active_q;
  logic               sclk_q;
  logic               done_q;
  logic [PH_W-1:0]    ph_q;
  logic [BIT_W-1:0]   bit_q;
  logic [FRAME_W-1:0] sreg_q;
  logic               ph_end;
  logic               last_bit;

  assign ph_end   = (ph_q == PH_W'(HALF_CYC - 1));
  assign last_bit = (bit_q == BIT_W'(FRAME_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      ph_q     <= '0;
      bit_q    <= '0;
      sreg_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        sreg_q   <= frame_i;
        ph_q     <= '0;
        bit_q    <= '0;
        sclk_q   <= 1'b0;
      end else if (active_q) begin
        if (!ph_end) begin
          ph_q <= ph_q + 1'b1;
        end else begin
          ph_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
          end else begin
            sclk_q <= 1'b0;
            if (last_bit) begin
              active_q <= 1'b0;
              sreg_q   <= '0;
              done_q   <= 1'b1;
            end else begin
              bit_q  <= bit_q + 1'b1;
              sreg_q <= sreg_q >> 1;
            end
          end
        end
      end
    end
  end

  assign sclk_o  = sclk_q;
  assign sdata_o = sreg_q[0];
  assign done_o  = done_q;
endmodule

// File: rtl/atten_latch_pulse.sv
module atten_latch_pulse
  import atten_ser_pkg::*;
#(
  parameter int LE_SU_CYC = 3,
  parameter int LE_PW_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic le_o,
  output logic rise_evt_o,
  output logic fall_evt_o
);
  localparam int MAXC = (LE_SU_CYC > LE_PW_CYC) ? LE_SU_CYC : LE_PW_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  lp_state_e       st_q;
  logic [CW-1:0]   cnt_q;
  logic            le_q;

  assign rise_evt_o = (st_q == LP_SETUP) && (cnt_q == CW'(LE_SU_CYC - 1));
  assign fall_evt_o = (st_q == LP_HIGH)  && (cnt_q == CW'(LE_PW_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= LP_IDLE;
      cnt_q <= '0;
      le_q  <= 1'b0;
    end else begin
      case (st_q)
        LP_IDLE: begin
          if (start_i) begin
            st_q  <= LP_SETUP;
            cnt_q <= '0;
          end
        end
        LP_SETUP: begin
          if (rise_evt_o) begin
            st_q  <= LP_HIGH;
            cnt_q <= '0;
            le_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        LP_HIGH: begin
          if (fall_evt_o) begin
            st_q  <= LP_IDLE;
            cnt_q <= '0;
            le_q  <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= LP_IDLE;
      endcase
    end
  end

  assign le_o = le_q;
endmodule

// File: rtl/atten_gap_timer.sv
module atten_gap_timer #(
  parameter int GAP_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic gap_ok_o
);
  localparam int GW = $clog2(GAP_CYC + 1);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= GW'(GAP_CYC);
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (cnt_q != GW'(GAP_CYC)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign gap_ok_o = (cnt_q == GW'(GAP_CYC));
endmodule

// File: rtl/atten_serial_master.sv
module atten_serial_master
  import atten_ser_pkg::*;
#(
  parameter int QDB_W     = 8,
  parameter int HALF_CYC  = 13,
  parameter int LE_SU_CYC = 3,
  parameter int LE_PW_CYC = 8,
  parameter int GAP_CYC   = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [QDB_W-1:0] req_qdb,
  input  logic [2:0]       req_addr,
  output logic             ser_clk,
  output logic             ser_data,
  output logic             ser_le,
  output logic             done
);
  seq_state_e         state_q;
  logic               done_q;
  logic [FRAME_W-1:0] frame;
  logic               accept;
  logic               shift_done;
  logic               le_rise_evt;
  logic               le_fall_evt;
  logic               gap_ok;

  assign req_ready = (state_q == SEQ_IDLE) && gap_ok;
  assign accept    = req_valid && req_ready;

  atten_frame_build #(.QDB_W(QDB_W)) frame_i (
    .qdb_i  (req_qdb),
    .addr_i (req_addr),
    .frame_o(frame)
  );

  atten_bit_shifter #(.HALF_CYC(HALF_CYC)) shifter_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(accept),
    .frame_i(frame),
    .sclk_o (ser_clk),
    .sdata_o(ser_data),
    .done_o (shift_done)
  );

  atten_latch_pulse #(.LE_SU_CYC(LE_SU_CYC), .LE_PW_CYC(LE_PW_CYC)) latch_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (shift_done),
    .le_o      (ser_le),
    .rise_evt_o(le_rise_evt),
    .fall_evt_o(le_fall_evt)
  );

  atten_gap_timer #(.GAP_CYC(GAP_CYC)) gap_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(le_rise_evt),
    .gap_ok_o (gap_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= le_fall_evt;
      case (state_q)
        SEQ_IDLE:  if (accept)      state_q <= SEQ_SHIFT;
        SEQ_SHIFT: if (shift_done)  state_q <= SEQ_LATCH;
        SEQ_LATCH: if (le_fall_evt) state_q <= SEQ_IDLE;
        default:                    state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign done = done_q;
endmodule

// File: rtl/atten_serial_master_chk.sv
module atten_serial_master_chk #(
  parameter int HALF_CYC  = 13,
  parameter int LE_PW_CYC = 8,
  parameter int GAP_CYC   = 10000
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_le,
  input logic done,
  input logic shift_done
);
  localparam int HW = $clog2(HALF_CYC + 2);
  localparam int LW = $clog2(LE_PW_CYC + 2);
  localparam int GW = $clog2(GAP_CYC + 2);

  logic          clk_q, le_q;
  logic [HW-1:0] run_c;
  logic [LW-1:0] le_run;
  logic [GW-1:0] gap_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_q  <= 1'b0;
      le_q   <= 1'b0;
      run_c  <= HW'(HALF_CYC);
      le_run <= '0;
      gap_c  <= GW'(GAP_CYC);
    end else begin
      clk_q <= ser_clk;
      le_q  <= ser_le;
      if (ser_clk != clk_q)            run_c <= HW'(1);
      else if (run_c < HW'(HALF_CYC))  run_c <= run_c + 1'b1;
      if (!ser_le)                     le_run <= '0;
      else if (le_run < LW'(LE_PW_CYC)) le_run <= le_run + 1'b1;
      if (ser_le && !le_q)             gap_c <= GW'(1);
      else if (gap_c < GW'(GAP_CYC))   gap_c <= gap_c + 1'b1;
    end
  end

  p_clk_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk != clk_q) |-> (run_c >= HW'(HALF_CYC)));

  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && clk_q) |-> $stable(ser_data));

  p_le_clk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le |-> !ser_clk);

  p_shift_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_done |-> (!ser_clk && !ser_le));

  p_le_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_le && le_q) |-> (le_run >= LW'(LE_PW_CYC)));

  p_le_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_le && !le_q) |-> (gap_c >= GW'(GAP_CYC)));

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ser_clk && !ser_le && !ser_data));

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_after_le_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_le && le_q) |-> done);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind atten_serial_master atten_serial_master_chk #(
  .HALF_CYC (HALF_CYC),
  .LE_PW_CYC(LE_PW_CYC),
  .GAP_CYC  (GAP_CYC)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ser_clk   (ser_clk),
  .ser_data  (ser_data),
  .ser_le    (ser_le),
  .done      (done),
  .shift_done(shift_done)
);

// File: tb/atten_serial_master_tb_top.sv
`timescale 1ns/1ps
module atten_serial_master_tb_top;
  localparam int HALF = 3;
  localparam int LESU = 2;
  localparam int LEPW = 4;
  localparam int GAP  = 300;
  localparam int NV   = 8;
  // {request qdb, address, expected code}
  localparam logic [23:0] VEC [NV] = '{
    {8'd73,  8'd3, 8'd73},  {8'd0,   8'd0, 8'd0},
    {8'd127, 8'd7, 8'd127}, {8'd128, 8'd5, 8'd127},
    {8'd255, 8'd1, 8'd127}, {8'd1,   8'd6, 8'd1},
    {8'd64,  8'd2, 8'd64},  {8'd42,  8'd4, 8'd42}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_qdb = '0;
  logic [2:0] req_addr = '0;
  logic req_ready, ser_clk, ser_data, ser_le, done;

  always #2 clk = ~clk;

  atten_serial_master #(.QDB_W(8), .HALF_CYC(HALF), .LE_SU_CYC(LESU),
                        .LE_PW_CYC(LEPW), .GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_qdb(req_qdb), .req_addr(req_addr), .ser_clk(ser_clk),
    .ser_data(ser_data), .ser_le(ser_le), .done(done));

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Pin monitor, sampled on the falling system clock edge.
  longint cyc = 0;
  logic [15:0] rx_sr = '0, last_frame = '0;
  int rx_bits = 0, last_bits = 0, frames = 0;
  bit pc = 0, pl = 0, pdat = 0, pdone = 0, have_le = 0;
  longint last_rise = 0, le_rise = 0;
  int hrun = 0, lrun = 0, min_high = 1000, min_lew = 1000;
  longint min_gap = 1000000, min_lesu = 1000000;
  int data_viol = 0, clk_le_viol = 0, done_miss = 0, done_bad = 0;

  always @(negedge clk) begin
    cyc++;
    if (ser_clk && !pc) begin
      rx_sr = {ser_data, rx_sr[15:1]};
      rx_bits++;
      last_rise = cyc;
    end
    if (ser_clk && pc && ser_data != pdat) data_viol++;
    if (ser_clk) hrun++;
    else if (pc) begin
      if (hrun < min_high) min_high = hrun;
      hrun = 0;
    end
    if (ser_le && !pl) begin
      if (cyc - last_rise < min_lesu) min_lesu = cyc - last_rise;
      if (have_le && (cyc - le_rise < min_gap)) min_gap = cyc - le_rise;
      have_le = 1;
      le_rise = cyc;
      last_frame = rx_sr;
      last_bits = rx_bits;
      rx_bits = 0;
      frames++;
    end
    if (ser_le && ser_clk) clk_le_viol++;
    if (ser_le) lrun++;
    else if (pl) begin
      if (lrun < min_lew) min_lew = lrun;
      lrun = 0;
      if (!done) done_miss++;
    end
    if (done && (pdone || ser_le || !pl)) done_bad++;
    pc = ser_clk; pl = ser_le; pdat = ser_data; pdone = done;
  end

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic issue(input logic [7:0] q, input logic [2:0] a);
    wait_ready();
    req_qdb = q; req_addr = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs while held in reset
    chk(!ser_clk && !ser_data && !ser_le && !done, "R11", "outputs in reset",
        {ser_clk, ser_data, ser_le, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
    chk(!ser_clk && !ser_le, "R4", "idle clock and latch low", {ser_clk, ser_le}, 0);

    // Vector table: R1 clamp, R2 order, R3 zero bits
    for (int i = 0; i < NV; i++) begin
      logic [7:0] q, c;
      logic [2:0] a;
      logic [15:0] exp_f;
      int f0;
      q = VEC[i][23:16]; a = VEC[i][10:8]; c = VEC[i][7:0];
      exp_f = {5'b0, a, 1'b0, c[6:0]};
      f0 = frames;
      issue(q, a);
      chk(req_ready == 1'b0, "R9", "ready drops after accept", req_ready, 0);
      wait_done();
      chk(req_ready == 1'b0, "R9", "ready low in quiet window", req_ready, 0);
      chk(last_frame == exp_f, "R1", "frame code/address", last_frame, exp_f);
      chk(last_frame[7] == 1'b0 && last_frame[15:11] == 5'b0, "R3",
          "forced-zero bits", last_frame, exp_f);
      chk(last_bits == 16, "R2", "bits per frame", last_bits, 16);
      chk(frames == f0 + 1, "R2", "one latch per request", frames, f0 + 1);
    end

    // Busy window: a different request held during the frame and quiet window
    begin
      int f0, rdy_seen;
      f0 = frames; rdy_seen = 0;
      issue(8'd20, 3'd2);
      req_qdb = 8'd99; req_addr = 3'd6; req_valid = 1'b1;
      while (!done) begin
        if (req_ready) rdy_seen++;
        @(negedge clk);
      end
      repeat (50) begin
        if (req_ready) rdy_seen++;
        @(negedge clk);
      end
      req_valid = 1'b0;
      chk(rdy_seen == 0, "R9", "ready while busy", rdy_seen, 0);
      chk(last_frame == {5'b0, 3'd2, 1'b0, 7'd20}, "R9", "busy request ignored",
          last_frame, {5'b0, 3'd2, 1'b0, 7'd20});
      wait_ready();
      repeat (40) @(negedge clk);
      chk(frames == f0 + 1, "R9", "no latch from ignored request", frames, f0 + 1);
    end

    // Timing measured at the pins over all updates so far
    chk(min_high >= HALF, "R4", "min clock high phase", min_high, HALF);
    chk(data_viol == 0, "R5", "data changes while clock high", data_viol, 0);
    chk(min_lesu >= HALF + LESU, "R6", "last clock rise to latch", min_lesu, HALF + LESU);
    chk(clk_le_viol == 0, "R6", "clock high during latch", clk_le_viol, 0);
    chk(min_lew >= LEPW, "R7", "latch width", min_lew, LEPW);
    chk(min_gap >= GAP, "R8", "latch spacing", min_gap, GAP);
    chk(done_miss == 0, "R10", "done missing after latch", done_miss, 0);
    chk(done_bad == 0, "R10", "done wide or misplaced", done_bad, 0);

    // Reset in mid-frame
    begin
      int f0;
      f0 = frames;
      issue(8'd33, 3'd1);
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!ser_clk && !ser_data && !ser_le && !done, "R11", "outputs after mid-frame reset",
          {ser_clk, ser_data, ser_le, done}, 0);
      chk(req_ready == 1'b1, "R11", "ready after mid-frame reset", req_ready, 1);
      rst_n = 1'b1;
      repeat (200) @(negedge clk);
      chk(frames == f0, "R11", "no latch from aborted frame", frames, f0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule